// File: doc/BRIEF.md
# Timer/Counter with Match Outputs and Input Capture

A 16-bit timer/counter driven by a 16-bit prescaler. Software writes a terminal value into the prescaler. The counter steps once each time the prescaler wraps. The prescaler advances either on every clock or, in event mode, on edges of one selected capture input. Four compare channels watch the count. On a hit, each channel can do any mix of three things: raise an interrupt, zero the counter, or halt it. Each channel also drives its own output pin, which it can pull low, drive high, toggle or leave alone.

Three capture channels sample the running count when their input changes. Each channel has its own edge choice and its own interrupt enable. A capture input that feeds the counter in event mode still works as a normal capture channel. All inputs pass through a two-flop synchronizer before edge detection. Configuration and status go through a flat word-addressed register port. Writes are single-cycle and reads are combinational.

Top module: `tmr_match_cap`

## Requirements
- R1: The prescale count (address 3) runs from 0 up to the terminal value (address 1), then returns to 0 on the next tick. On that wrap tick the count (address 2) steps by one and rolls over from 0xFFFF to 0. On every other tick the count is unchanged.
- R2: A tick happens on every clock when the enable bit (CTRL bit 0) is 1, the hold bit (CTRL bit 1) is 0 and the mode bit (CTRL bit 2) is 0. With the enable bit at 0, the count and the prescale count stay frozen.
- R3: While the hold bit (CTRL bit 1) is 1, the count and the prescale count read 0 from the cycle after it is written.
- R4: Compare channel i hits on a wrap tick while the count equals its compare value (address 8+i). If the reset bit of a hitting channel (MCTL bit 3i+1) is set, the count is 0 on the next cycle.
- R5: If a hitting channel has its halt bit (MCTL bit 3i+2) set and no hitting channel has its reset bit set, three things happen on the next cycle: the count holds its value, the prescale count is 0 and the enable bit reads 0. A halt in the same cycle as a software write to CTRL wins over that write.
- R6: When reset and halt hits fall in the same cycle, the reset wins: the count goes to 0 and the enable bit stays 1. A hit with no action bits set leaves the counter running.
- R7: On a hit, output pin i follows its 2-bit field OCTL[2i+1:2i]: 0 keeps the pin, 1 drives it low, 2 drives it high, 3 toggles it. Several channels hitting in one cycle all apply their actions. The pins reset to 0.
- R8: Capture channel c is armed by CCTL bit 3c for rising edges and by CCTL bit 3c+1 for falling edges; either or both may be set. A change on input c at clock edge k loads capture register 12+c at edge k+2 with the count held just before that edge.
- R9: When the mode bit (CTRL bit 2) is 1, the prescaler ticks on edges of input CTRL[5:4], with the same two-cycle synchronizer delay as capture. CTRL bit 6 selects rising edges and CTRL bit 7 selects falling edges. The other capture channels keep capturing normally.
- R10: Status (address 7) has bit i set by a hit on compare channel i when MCTL bit 3i is 1. It has bit 4+c set by a capture on channel c when CCTL bit 3c+2 is 1. Writing 1 to a status bit clears it, but a set in the same cycle wins over the clear. irq_o is the OR of all status bits.
- R11: The register map is CTRL 0, terminal value 1, count 2, prescale count 3, MCTL 4, OCTL 5, CCTL 6, status 7, compare 8 to 11 and capture 12 to 14. Writes to 2, 3 and 12 to 14 are ignored. Address 15 reads 0, and every register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| cap_i | input | 3 | Capture and event inputs, asynchronous |
| match_o | output | 4 | Compare channel output pins |
| irq_o | output | 1 | Interrupt request, OR of status bits |

## Verification
The main collision arises when two compare channels share one compare value, one set to zero the counter and the other set to halt it, so both hit on the same wrap tick. The bench sets this up and requires that the count returns to 0 while the enable bit stays 1. A second collision is a capture edge on the same input that drives the counter in event mode. The count must advance and the capture register must take the pre-advance value in the same cycle. A behavioural model run in lockstep judges the pins, irq_o and the addressed register on every clock.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int CNT_W     = 16;
  localparam int NUM_MATCH = 4;
  localparam int NUM_CAP   = 3;
  localparam int ADDR_W    = 4;
  localparam int SRC_W     = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_TERM   = 4'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_PCOUNT = 4'd3;
  localparam logic [ADDR_W-1:0] A_MCTL   = 4'd4;
  localparam logic [ADDR_W-1:0] A_OCTL   = 4'd5;
  localparam logic [ADDR_W-1:0] A_CCTL   = 4'd6;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd7;
  localparam logic [ADDR_W-1:0] A_CMP0   = 4'd8;
  localparam logic [ADDR_W-1:0] A_CAP0   = 4'd12;

  localparam int CB_EN   = 0;
  localparam int CB_HOLD = 1;
  localparam int CB_MODE = 2;
  localparam int CB_SRC  = 4;
  localparam int CB_RISE = 6;
  localparam int CB_FALL = 7;

  typedef enum logic [1:0] {
    OUT_KEEP   = 2'd0,
    OUT_LOW    = 2'd1,
    OUT_HIGH   = 2'd2,
    OUT_TOGGLE = 2'd3
  } out_act_e;
endpackage

// File: rtl/tmr_edge_det.sv
`timescale 1ns/1ps
module tmr_edge_det #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= in_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/tmr_presc_cnt.sv
`timescale 1ns/1ps
module tmr_presc_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         tick_i,
  input  logic [W-1:0] term_i,
  input  logic         zero_i,
  input  logic         freeze_i,
  output logic [W-1:0] tc_o,
  output logic [W-1:0] pc_o,
  output logic         adv_o
);
  logic [W-1:0] tc_q, pc_q;
  logic         wrap;

  assign wrap  = (pc_q == term_i);
  assign adv_o = tick_i & wrap;
  assign tc_o  = tc_q;
  assign pc_o  = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (hold_i) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (tick_i) begin
      if (wrap) begin
        pc_q <= '0;
        if (zero_i)        tc_q <= '0;
        else if (!freeze_i) tc_q <= tc_q + 1'b1;
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  // R3
  hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (tc_q == '0 && pc_q == '0));
  // R1
  no_step_midway_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wrap && !hold_i) |=> $stable(tc_q));
  // R2
  idle_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !hold_i) |=> ($stable(tc_q) && $stable(pc_q)));
endmodule

// File: rtl/tmr_match_out.sv
`timescale 1ns/1ps
module tmr_match_out
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic [1:0] mode_i,
  output logic       pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else if (hit_i) begin
      case (out_act_e'(mode_i))
        OUT_LOW:    pin_q <= 1'b0;
        OUT_HIGH:   pin_q <= 1'b1;
        OUT_TOGGLE: pin_q <= ~pin_q;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o = pin_q;

  // R7
  pin_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(pin_q));
endmodule

// File: rtl/tmr_match_cap.sv
`timescale 1ns/1ps
module tmr_match_cap
  import tmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int NM = NUM_MATCH,
  parameter int NC = NUM_CAP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CW-1:0]     wdata_i,
  output logic [CW-1:0]     rdata_o,
  input  logic [NC-1:0]     cap_i,
  output logic [NM-1:0]     match_o,
  output logic              irq_o
);
  localparam int NI = NM + NC;

  logic             en_q, hold_q, mode_q;
  logic [SRC_W-1:0] src_q;
  logic [1:0]       cedge_q;
  logic [CW-1:0]    term_q;
  logic [3*NM-1:0]  mctl_q;
  logic [2*NM-1:0]  octl_q;
  logic [3*NC-1:0]  cctl_q;
  logic [NI-1:0]    stat_q;
  logic [CW-1:0]    cmp_q [NM];
  logic [CW-1:0]    cap_q [NC];

  logic [NC-1:0] rise, fall, cap_ev;
  logic [NM-1:0] hit, rst_en, stop_en, irq_en;
  logic [NI-1:0] stat_set, stat_clr;
  logic [CW-1:0] tc, pc;
  logic          adv, tick, cnt_ev, do_rst, do_stop, wr_ctrl;

  tmr_edge_det #(.W(NC)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(cap_i), .rise_o(rise), .fall_o(fall)
  );

  always_comb begin
    cnt_ev = 1'b0;
    for (int c = 0; c < NC; c++) begin
      cap_ev[c] = (cctl_q[3*c] & rise[c]) | (cctl_q[3*c+1] & fall[c]);
      if (src_q == SRC_W'(c))
        cnt_ev = (cedge_q[0] & rise[c]) | (cedge_q[1] & fall[c]);
    end
  end

  assign tick = en_q & ~hold_q & (mode_q ? cnt_ev : 1'b1);

  tmr_presc_cnt #(.W(CW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_q), .tick_i(tick),
    .term_i(term_q), .zero_i(do_rst), .freeze_i(do_stop),
    .tc_o(tc), .pc_o(pc), .adv_o(adv)
  );

  for (genvar i = 0; i < NM; i++) begin : g_match
    assign irq_en[i]  = mctl_q[3*i];
    assign rst_en[i]  = mctl_q[3*i+1];
    assign stop_en[i] = mctl_q[3*i+2];
    assign hit[i]     = adv & (tc == cmp_q[i]);
    tmr_match_out u_out (
      .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit[i]),
      .mode_i(octl_q[2*i+1:2*i]), .pin_o(match_o[i])
    );
  end

  // reset action outranks halt
  assign do_rst  = |(hit & rst_en);
  assign do_stop = |(hit & stop_en) & ~do_rst;

  always_comb begin
    for (int c = 0; c < NC; c++) stat_set[NM+c] = cap_ev[c] & cctl_q[3*c+2];
    stat_set[NM-1:0] = hit & irq_en;
  end
  assign stat_clr = (we_i && addr_i == A_STAT) ? wdata_i[NI-1:0] : '0;
  assign wr_ctrl  = we_i && addr_i == A_CTRL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; hold_q <= 1'b0; mode_q <= 1'b0;
      src_q <= '0; cedge_q <= '0; term_q <= '0;
      mctl_q <= '0; octl_q <= '0; cctl_q <= '0; stat_q <= '0;
      for (int i = 0; i < NM; i++) cmp_q[i] <= '0;
      for (int c = 0; c < NC; c++) cap_q[c] <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      if (do_stop)      en_q <= 1'b0;
      else if (wr_ctrl) en_q <= wdata_i[CB_EN];
      if (wr_ctrl) begin
        hold_q  <= wdata_i[CB_HOLD];
        mode_q  <= wdata_i[CB_MODE];
        src_q   <= wdata_i[CB_SRC +: SRC_W];
        cedge_q <= {wdata_i[CB_FALL], wdata_i[CB_RISE]};
      end
      if (we_i) begin
        case (addr_i)
          A_TERM: term_q <= wdata_i;
          A_MCTL: mctl_q <= wdata_i[3*NM-1:0];
          A_OCTL: octl_q <= wdata_i[2*NM-1:0];
          A_CCTL: cctl_q <= wdata_i[3*NC-1:0];
          default: ;
        endcase
        for (int i = 0; i < NM; i++)
          if (addr_i == A_CMP0 + ADDR_W'(i)) cmp_q[i] <= wdata_i;
      end
      for (int c = 0; c < NC; c++)
        if (cap_ev[c]) cap_q[c] <= tc;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[CB_EN]           = en_q;
        rdata_o[CB_HOLD]         = hold_q;
        rdata_o[CB_MODE]         = mode_q;
        rdata_o[CB_SRC +: SRC_W] = src_q;
        rdata_o[CB_RISE]         = cedge_q[0];
        rdata_o[CB_FALL]         = cedge_q[1];
      end
      A_TERM:   rdata_o = term_q;
      A_COUNT:  rdata_o = tc;
      A_PCOUNT: rdata_o = pc;
      A_MCTL:   rdata_o[3*NM-1:0] = mctl_q;
      A_OCTL:   rdata_o[2*NM-1:0] = octl_q;
      A_CCTL:   rdata_o[3*NC-1:0] = cctl_q;
      A_STAT:   rdata_o[NI-1:0] = stat_q;
      default: ;
    endcase
    for (int i = 0; i < NM; i++)
      if (addr_i == A_CMP0 + ADDR_W'(i)) rdata_o = cmp_q[i];
    for (int c = 0; c < NC; c++)
      if (addr_i == A_CAP0 + ADDR_W'(c)) rdata_o = cap_q[c];
  end

  assign irq_o = |stat_q;

  // R5
  halt_clears_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_stop |=> !en_q);
  // R4
  reset_hit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_rst |=> (tc == '0));
  // R10
  stat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q != '0) && !(we_i && addr_i == A_STAT)) |=> irq_o);
endmodule

// File: tb/sim_tmr_match_cap.sv
`timescale 1ns/1ps
module sim_tmr_match_cap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  cap = '0;
  logic [3:0]  pins;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  tmr_match_cap u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cap_i(cap), .match_o(pins), .irq_o(irq)
  );

  // behavioural reference
  logic [15:0] m_tc = '0, m_pc = '0, m_term = '0;
  logic        m_en = 0, m_hold = 0, m_mode = 0;
  logic [1:0]  m_src = '0, m_ce = '0;
  logic [11:0] m_mctl = '0;
  logic [7:0]  m_octl = '0;
  logic [8:0]  m_cctl = '0;
  logic [6:0]  m_stat = '0;
  logic [3:0]  m_pin = '0;
  logic [15:0] m_cmp [4] = '{default: '0};
  logic [15:0] m_cap [3] = '{default: '0};
  logic [2:0]  hist [$] = '{3'b0, 3'b0, 3'b0};

  function automatic logic [15:0] model_rd(input logic [3:0] a);
    case (a)
      4'd0: return {8'b0, m_ce[1], m_ce[0], m_src, 1'b0, m_mode, m_hold, m_en};
      4'd1: return m_term;
      4'd2: return m_tc;
      4'd3: return m_pc;
      4'd4: return {4'b0, m_mctl};
      4'd5: return {8'b0, m_octl};
      4'd6: return {7'b0, m_cctl};
      4'd7: return {9'b0, m_stat};
      4'd8, 4'd9, 4'd10, 4'd11: return m_cmp[a-8];
      4'd12, 4'd13, 4'd14: return m_cap[a-12];
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd1, 4'd2, 4'd3: return "R1";
      4'd7: return "R10";
      4'd8, 4'd9, 4'd10, 4'd11: return "R4";
      4'd12, 4'd13, 4'd14: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic model_step();
    logic [2:0] s2, s3, rise, fall, cev;
    logic [3:0] hit;
    logic cnt_ev, tick, adv, rst_hit, stp;
    logic [15:0] n_tc, n_pc;
    logic [6:0] set, clr;
    s2 = hist[1]; s3 = hist[2];
    rise = s2 & ~s3; fall = ~s2 & s3;
    for (int c = 0; c < 3; c++) cev[c] = (m_cctl[3*c] & rise[c]) | (m_cctl[3*c+1] & fall[c]);
    cnt_ev = (m_src < 3) && ((m_ce[0] && rise[m_src]) || (m_ce[1] && fall[m_src]));
    tick = m_en && !m_hold && (m_mode ? cnt_ev : 1'b1);
    adv = tick && (m_pc == m_term);
    rst_hit = 0; stp = 0; set = '0;
    for (int i = 0; i < 4; i++) begin
      hit[i] = adv && (m_tc == m_cmp[i]);
      if (hit[i] && m_mctl[3*i+1]) rst_hit = 1;
      if (hit[i] && m_mctl[3*i+2]) stp = 1;
      if (hit[i] && m_mctl[3*i]) set[i] = 1;
      if (hit[i])
        case (m_octl[2*i +: 2])
          2'd1: m_pin[i] = 0;
          2'd2: m_pin[i] = 1;
          2'd3: m_pin[i] = ~m_pin[i];
          default: ;
        endcase
    end
    if (rst_hit) stp = 0;
    n_tc = m_tc; n_pc = m_pc;
    if (m_hold) begin n_tc = 0; n_pc = 0; end
    else if (tick) begin
      if (adv) begin
        n_pc = 0;
        if (rst_hit) n_tc = 0; else if (!stp) n_tc = m_tc + 16'd1;
      end else n_pc = m_pc + 16'd1;
    end
    for (int c = 0; c < 3; c++) begin
      if (cev[c]) m_cap[c] = m_tc;
      if (cev[c] && m_cctl[3*c+2]) set[4+c] = 1;
    end
    clr = (we && addr == 4'd7) ? wdata[6:0] : 7'd0;
    m_stat = (m_stat & ~clr) | set;
    if (stp) m_en = 0;
    else if (we && addr == 4'd0) m_en = wdata[0];
    if (we) begin
      case (addr)
        4'd0: begin m_hold = wdata[1]; m_mode = wdata[2]; m_src = wdata[5:4]; m_ce = wdata[7:6]; end
        4'd1: m_term = wdata;
        4'd4: m_mctl = wdata[11:0];
        4'd5: m_octl = wdata[7:0];
        4'd6: m_cctl = wdata[8:0];
        4'd8, 4'd9, 4'd10, 4'd11: m_cmp[addr-8] = wdata;
        default: ;
      endcase
    end
    m_tc = n_tc; m_pc = n_pc;
    hist.push_front(cap);
    void'(hist.pop_back());
  endtask

  always @(posedge clk) begin
    if (rst_n) model_step();
  end

  // lockstep comparison, away from the active edge
  always @(negedge clk) begin
    logic [15:0] e;
    e = model_rd(addr);
    tests++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s addr=%0d rdata actual=%h expected=%h", tag_of(addr), addr, rdata, e);
    end
    tests++;
    if (pins !== m_pin) begin
      fails++;
      $display("FAIL R7 match_o actual=%b expected=%b", pins, m_pin);
    end
    tests++;
    if (irq !== (|m_stat)) begin
      fails++;
      $display("FAIL R10 irq_o actual=%b expected=%b", irq, |m_stat);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d cycles expected=below 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(posedge clk); #1;
    we = 0; addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse(input int ch, input int hi, input int lo);
    @(posedge clk); #1; cap[ch] = 1'b1;
    repeat (hi) @(posedge clk);
    #1; cap[ch] = 1'b0;
    repeat (lo) @(posedge clk);
  endtask

  initial begin
    logic [15:0] v, a0;
    #35 rst_n = 1;

    // R11: reset values across the map
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk("R11", v, 0);
    end

    // R1 R4 R7 R10: terminal 2, compare 5 with reset, irq and toggle
    wr(4'd1, 16'd2);
    wr(4'd8, 16'd5);
    wr(4'd4, 16'h0003);
    wr(4'd5, 16'h0003);
    wr(4'd0, 16'h0001);
    idle(10);
    for (int k = 0; k < 6; k++) begin
      rd(4'd2, v);
      chk("R4", int'(v <= 16'd5), 1);
      rd(4'd3, v);
      chk("R1", int'(v <= 16'd2), 1);
    end
    idle(20);
    rd(4'd7, v);
    chk("R10", v[0], 1);
    wr(4'd0, 16'h0000);
    rd(4'd2, a0);
    idle(6);
    rd(4'd2, v);
    chk("R2", v, a0);
    wr(4'd2, 16'h1234);
    rd(4'd2, v);
    chk("R11", v, a0);
    wr(4'd7, 16'h0001);
    rd(4'd7, v);
    chk("R10", v, 0);

    // R3: hold zeroes counter and prescaler
    wr(4'd0, 16'h0003);
    idle(5);
    rd(4'd2, v);
    chk("R3", v, 0);
    rd(4'd3, v);
    chk("R3", v, 0);

    // R5: halt alone at 3
    wr(4'd1, 16'd0);
    wr(4'd4, 16'h0020);
    wr(4'd9, 16'd3);
    wr(4'd0, 16'h0001);
    idle(12);
    rd(4'd2, v);
    chk("R5", v, 3);
    rd(4'd0, v);
    chk("R5", v[0], 0);

    // R6 R7: reset on ch2 and halt on ch1 both at 3
    wr(4'd0, 16'h0002);
    wr(4'd10, 16'd3);
    wr(4'd4, 16'h00A0);
    wr(4'd5, 16'h0018);
    wr(4'd0, 16'h0001);
    idle(20);
    rd(4'd0, v);
    chk("R6", v[0], 1);
    rd(4'd2, v);
    chk("R6", int'(v <= 16'd3), 1);
    chk("R7", pins[1], 1);
    chk("R7", pins[2], 0);

    // R8: free-running count, capture edges of each kind
    wr(4'd4, 16'h0000);
    wr(4'd6, 16'h00D5);
    pulse(0, 4, 5);
    pulse(1, 3, 6);
    pulse(2, 2, 7);
    idle(3);
    rd(4'd12, v);
    chk("R8", v, m_cap[0]);
    rd(4'd7, v);
    chk("R10", v[4], 1);
    rd(4'd14, v);
    chk("R8", v, m_cap[2]);

    // R9: event mode on input 1 rising, input 0 still captures
    wr(4'd0, 16'h0057);
    wr(4'd0, 16'h0055);
    for (int k = 0; k < 4; k++) begin
      pulse(1, 3, 3);
      if (k == 1) pulse(0, 2, 2);
    end
    idle(4);
    rd(4'd2, v);
    chk("R9", v, 4);
    rd(4'd12, v);
    chk("R9", v, m_cap[0]);
    chk("R9", int'(v == 16'd2), 1);

    idle(4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule